// File: doc/BRIEF.md
# Multi-Queue Transmit Channel Scheduler

The block sits between a set of circular transmit descriptor queues and a small number of transmit FIFO channels with fixed priorities. Software programs one configuration word per queue, naming the channel the queue feeds, whether the queue takes part in scheduling, and whether it runs in window-acknowledged or in-order mode. Each cycle the block looks at which queues have a descriptor waiting and which channels can accept one. It then issues at most one registered grant that names a queue, its channel and the queue's mode.

Several queues may feed the same channel. Those queues share it in round-robin order, resuming after the queue granted last on that channel. Between channels, the channel with the higher index wins. One channel is reserved for commands. A queue steered to it is always held in in-order mode, whatever software writes into the mode bit.

Top module: `txq_fifo_sched`

## Requirements
- R1: After reset no queue is active, every rotation pointer points at the last queue, and `gnt_valid` is low.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the configuration of queue `cfg_qsel`. The channel number comes from bits [CH_W-1:0], the active flag from bit 3 and the window-ack flag from bit 19. All other bits have no effect.
- R3: A queue takes part only while its active flag is set and its `q_avail` bit is high. A write that clears the active flag is seen by arbitration from the clock edge after the one that stores it.
- R4: A grant for a channel is issued only if that channel's `ch_ready` bit was high. The grant is registered and appears one clock after the inputs that produced it.
- R5: At most one grant is issued per clock. When several channels have ready, eligible work, the channel with the highest index is served.
- R6: Among eligible queues mapped to one channel, the grant goes to the first eligible queue after the one last granted on that channel, wrapping from the highest index to queue 0.
- R7: A queue whose written channel equals the command channel CMD_CH (default 7) is stored in in-order mode even if bit 19 is set, so its grants always show `gnt_winack` = 0.
- R8: For every other channel, `gnt_winack` equals the window-ack flag last written for the granted queue.
- R9: In a cycle with no grant, `gnt_queue` and `gnt_chan` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qsel | input | Q_W | Queue whose configuration is written |
| cfg_wdata | input | 32 | Configuration word |
| q_avail | input | NUM_Q | Per-queue descriptor-waiting flags |
| ch_ready | input | NUM_CH | Per-channel accept flags |
| gnt_valid | output | 1 | Grant strobe |
| gnt_queue | output | Q_W | Granted queue |
| gnt_chan | output | CH_W | Channel of the granted queue |
| gnt_winack | output | 1 | Mode of the granted queue, 1 = window-ack |

## Verification
The bench builds the block with its defaults: sixteen queues, eight channels, and the command channel at index 7 with higher indices winning. With these values the full channel field and the reserved command channel are both exercised. Round-robin wrap-around is reached across a queue space where the last-granted pointer starts at 15. A command-channel grant can also be set against a voice-channel grant to show the priority order.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;
   localparam int MAX_Q      = 16;
   localparam int MAX_CH     = 8;
   localparam int MAX_CH_W   = 3;
   localparam int CFG_W      = 32;
   localparam int ACT_BIT    = 3;
   localparam int WINACK_BIT = 19;

   typedef struct packed {
      logic                winack;
      logic                act;
      logic [MAX_CH_W-1:0] ch;
   } q_cfg_t;
endpackage

// File: rtl/txq_cfg_bank.sv
module txq_cfg_bank
   import txq_sched_pkg::*;
#(
   parameter int NUM_Q  = 16,
   parameter int NUM_CH = 8,
   parameter int CMD_CH = 7,
   localparam int Q_W   = $clog2(NUM_Q),
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [Q_W-1:0]       sel,
   input  logic [CFG_W-1:0]     wdata,
   output q_cfg_t [NUM_Q-1:0]   cfg_o
);
   q_cfg_t wr_val;
   logic   is_cmd;

   generate
      if (CMD_CH < NUM_CH) begin : g_cmd
         assign is_cmd = (wdata[CH_W-1:0] == CH_W'(CMD_CH));
      end else begin : g_nocmd
         assign is_cmd = 1'b0;
      end
   endgenerate

   always_comb begin
      wr_val        = '0;
      wr_val.ch     = MAX_CH_W'(wdata[CH_W-1:0]);
      wr_val.act    = wdata[ACT_BIT];
      wr_val.winack = wdata[WINACK_BIT] & ~is_cmd;
   end

   generate
      for (genvar q = 0; q < NUM_Q; q++) begin : g_q
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cfg_o[q] <= '0;
            else if (we && (sel == Q_W'(q)))
               cfg_o[q] <= wr_val;
         end
      end
   endgenerate
endmodule

// File: rtl/txq_rr_pick.sv
module txq_rr_pick #(
   parameter int NUM_Q = 16,
   localparam int Q_W  = $clog2(NUM_Q)
) (
   input  logic [NUM_Q-1:0] req,
   input  logic [Q_W-1:0]   last,
   output logic             hit,
   output logic [Q_W-1:0]   idx
);
   int j;
   always_comb begin
      hit = 1'b0;
      idx = '0;
      j   = 0;
      for (int i = 1; i <= NUM_Q; i++) begin
         j = (int'(last) + i) % NUM_Q;
         if (!hit && req[j]) begin
            hit = 1'b1;
            idx = Q_W'(j);
         end
      end
   end
endmodule

// File: rtl/txq_prio_sel.sv
module txq_prio_sel #(
   parameter int NUM_CH     = 8,
   parameter bit HIGH_FIRST = 1'b1,
   localparam int CH_W      = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] req,
   output logic              hit,
   output logic [CH_W-1:0]   idx
);
   generate
      if (HIGH_FIRST) begin : g_high
         always_comb begin
            hit = 1'b0;
            idx = '0;
            for (int c = NUM_CH - 1; c >= 0; c--) begin
               if (!hit && req[c]) begin
                  hit = 1'b1;
                  idx = CH_W'(c);
               end
            end
         end
      end else begin : g_low
         always_comb begin
            hit = 1'b0;
            idx = '0;
            for (int c = 0; c < NUM_CH; c++) begin
               if (!hit && req[c]) begin
                  hit = 1'b1;
                  idx = CH_W'(c);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/txq_fifo_sched.sv
module txq_fifo_sched
   import txq_sched_pkg::*;
#(
   parameter int NUM_Q      = 16,
   parameter int NUM_CH     = 8,
   parameter int CMD_CH     = 7,
   parameter bit HIGH_FIRST = 1'b1,
   localparam int Q_W       = $clog2(NUM_Q),
   localparam int CH_W      = $clog2(NUM_CH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [Q_W-1:0]     cfg_qsel,
   input  logic [31:0]        cfg_wdata,
   input  logic [NUM_Q-1:0]   q_avail,
   input  logic [NUM_CH-1:0]  ch_ready,
   output logic               gnt_valid,
   output logic [Q_W-1:0]     gnt_queue,
   output logic [CH_W-1:0]    gnt_chan,
   output logic               gnt_winack
);
   generate
      if (NUM_Q < 2 || NUM_Q > MAX_Q) begin : g_bad_q
         $error("txq_fifo_sched: NUM_Q out of range");
      end
      if (NUM_CH < 2 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("txq_fifo_sched: NUM_CH out of range");
      end
   endgenerate

   q_cfg_t [NUM_Q-1:0] cfg;
   logic [NUM_Q-1:0]   elig    [NUM_CH];
   logic [NUM_CH-1:0]  ch_req;
   logic [NUM_CH-1:0]  pick_hit;
   logic [Q_W-1:0]     pick_idx [NUM_CH];
   logic [Q_W-1:0]     rr_last  [NUM_CH];
   logic               sel_hit;
   logic [CH_W-1:0]    win_ch;
   logic [Q_W-1:0]     win_q;

   txq_cfg_bank #(.NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .CMD_CH(CMD_CH)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .sel   (cfg_qsel),
      .wdata (cfg_wdata),
      .cfg_o (cfg)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         for (genvar q = 0; q < NUM_Q; q++) begin : g_el
            assign elig[c][q] = cfg[q].act & q_avail[q] &
                                (cfg[q].ch == MAX_CH_W'(c));
         end

         txq_rr_pick #(.NUM_Q(NUM_Q)) u_rr (
            .req  (elig[c]),
            .last (rr_last[c]),
            .hit  (pick_hit[c]),
            .idx  (pick_idx[c])
         );

         assign ch_req[c] = pick_hit[c] & ch_ready[c];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rr_last[c] <= Q_W'(NUM_Q - 1);
            else if (sel_hit && (win_ch == CH_W'(c)))
               rr_last[c] <= pick_idx[c];
         end
      end
   endgenerate

   txq_prio_sel #(.NUM_CH(NUM_CH), .HIGH_FIRST(HIGH_FIRST)) u_prio (
      .req (ch_req),
      .hit (sel_hit),
      .idx (win_ch)
   );

   assign win_q = pick_idx[win_ch];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_valid  <= 1'b0;
         gnt_queue  <= '0;
         gnt_chan   <= '0;
         gnt_winack <= 1'b0;
      end else begin
         gnt_valid  <= sel_hit;
         gnt_queue  <= sel_hit ? win_q  : '0;
         gnt_chan   <= sel_hit ? win_ch : '0;
         gnt_winack <= sel_hit & cfg[win_q].winack;
      end
   end
endmodule

// File: rtl/txq_sched_chk.sv
module txq_sched_chk #(
   parameter int NUM_Q  = 16,
   parameter int NUM_CH = 8,
   parameter int CMD_CH = 7,
   localparam int Q_W   = $clog2(NUM_Q),
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_Q-1:0]  q_avail,
   input logic [NUM_CH-1:0] ch_ready,
   input logic              gnt_valid,
   input logic [Q_W-1:0]    gnt_queue,
   input logic [CH_W-1:0]   gnt_chan,
   input logic              gnt_winack
);
   logic [NUM_Q-1:0]  prev_avail;
   logic [NUM_CH-1:0] prev_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_avail <= '0;
         prev_ready <= '0;
      end else begin
         prev_avail <= q_avail;
         prev_ready <= ch_ready;
      end
   end

   assert_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> prev_ready[gnt_chan]);

   assert_avail_R3: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> prev_avail[gnt_queue]);

   assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_valid |-> (gnt_queue == '0 && gnt_chan == '0 && !gnt_winack));

   assert_nowork_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_avail == '0) |-> !gnt_valid);

   generate
      if (CMD_CH < NUM_CH) begin : g_cmd
         assert_cmd_inorder_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_valid && gnt_chan == CH_W'(CMD_CH)) |-> !gnt_winack);
      end
   endgenerate
endmodule

bind txq_fifo_sched txq_sched_chk #(.NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .CMD_CH(CMD_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .q_avail    (q_avail),
   .ch_ready   (ch_ready),
   .gnt_valid  (gnt_valid),
   .gnt_queue  (gnt_queue),
   .gnt_chan   (gnt_chan),
   .gnt_winack (gnt_winack)
);

// File: tb/tb_txq_fifo_sched.sv
module tb_txq_fifo_sched;
   localparam int CLK_P  = 10;
   localparam int NUM_Q  = 16;
   localparam int NUM_CH = 8;
   localparam int Q_W    = 4;
   localparam int CH_W   = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [Q_W-1:0]    cfg_qsel = '0;
   logic [31:0]       cfg_wdata = '0;
   logic [NUM_Q-1:0]  q_avail = '0;
   logic [NUM_CH-1:0] ch_ready = '0;
   logic              gnt_valid;
   logic [Q_W-1:0]    gnt_queue;
   logic [CH_W-1:0]   gnt_chan;
   logic              gnt_winack;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   txq_fifo_sched dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_qsel(cfg_qsel),
      .cfg_wdata(cfg_wdata), .q_avail(q_avail), .ch_ready(ch_ready),
      .gnt_valid(gnt_valid), .gnt_queue(gnt_queue), .gnt_chan(gnt_chan),
      .gnt_winack(gnt_winack)
   );

   task automatic chk(string rq, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic expect_gnt(string rq, bit v, int q, int c, bit w);
      @(posedge clk);
      #1;
      chk({rq, " valid"}, int'(gnt_valid), int'(v));
      chk({rq, " queue"}, int'(gnt_queue), q);
      chk({rq, " chan"},  int'(gnt_chan),  c);
      chk({rq, " winack"}, int'(gnt_winack), int'(w));
   endtask

   task automatic wr(int q, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_qsel = Q_W'(q); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_wdata = '0;
   endtask

   function automatic logic [31:0] word(int ch, bit act, bit wa);
      return (32'(wa) << 19) | (32'(act) << 3) | 32'(ch);
   endfunction

   task automatic drive(logic [NUM_Q-1:0] a, logic [NUM_CH-1:0] r);
      @(negedge clk);
      q_avail = a; ch_ready = r;
   endtask

   // R1 R3: nothing active, nothing granted
   task automatic t_reset;
      #1;
      chk("R1 reset valid", int'(gnt_valid), 0);
      drive('1, '1);
      expect_gnt("R1 R3 inactive queues", 0, 0, 0, 0);
      drive('0, '0);
   endtask

   // R2 R4: single queue, ready gating
   task automatic t_single;
      wr(3, word(2, 1, 0));
      drive(16'h0008, 8'h04);
      expect_gnt("R4 single grant", 1, 3, 2, 0);
      drive(16'h0008, 8'h00);
      expect_gnt("R4 not ready", 0, 0, 0, 0);
      wr(6, 32'h0000_000A);   // ch field 2, active bit 3
      drive(16'h0040, 8'h04);
      expect_gnt("R2 field decode", 1, 6, 2, 0);
      drive('0, '0);
   endtask

   // R6: round robin on channel 1
   task automatic t_rr;
      wr(1, word(1, 1, 0));
      wr(2, word(1, 1, 0));
      wr(5, word(1, 1, 0));
      drive(16'h0026, 8'h02);
      expect_gnt("R6 rr first", 1, 1, 1, 0);
      expect_gnt("R6 rr second", 1, 2, 1, 0);
      expect_gnt("R6 rr third", 1, 5, 1, 0);
      expect_gnt("R6 rr wrap", 1, 1, 1, 0);
      drive(16'h0022, 8'h02);
      expect_gnt("R6 rr skip", 1, 5, 1, 0);
      expect_gnt("R6 rr skip wrap", 1, 1, 1, 0);
      drive('0, '0);
   endtask

   // R5: higher channel wins
   task automatic t_prio;
      drive(16'h000A, 8'h06);
      expect_gnt("R5 ch2 over ch1", 1, 3, 2, 0);
      drive(16'h000A, 8'h02);
      expect_gnt("R5 ch1 when ch2 busy", 1, 1, 1, 0);
      drive('0, '0);
   endtask

   // R3: deactivation timing
   task automatic t_deact;
      @(negedge clk);
      q_avail = 16'h0008; ch_ready = 8'h04;
      cfg_we = 1'b1; cfg_qsel = 4'd3; cfg_wdata = word(2, 0, 0);
      expect_gnt("R3 old config still used", 1, 3, 2, 0);
      @(negedge clk);
      cfg_we = 1'b0;
      expect_gnt("R3 cleared active", 0, 0, 0, 0);
      drive('0, '0);
   endtask

   // R7 R8: command channel forced in-order
   task automatic t_cmd;
      wr(9, word(7, 1, 1) | 32'h0007_FFF0);
      wr(4, word(3, 1, 1));
      drive(16'h0010, 8'hFF);
      expect_gnt("R8 winack reported", 1, 4, 3, 1);
      drive(16'h0210, 8'hFF);
      expect_gnt("R7 R5 cmd in-order, highest", 1, 9, 7, 0);
      drive('0, '0);
      expect_gnt("R9 idle fields", 0, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_rr();
      t_prio();
      t_deact();
      t_cmd();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule